// File: doc/BRIEF.md
# Interrupt Aggregator with Mask Registers

This block takes six level-sensitive interrupt requests and folds them into one level-sensitive interrupt line toward a host. The requests come from a serial-flash controller, two two-wire bus controllers, two streaming DMA channels and a common-interface module. Each request can be let through or blocked by its own bit in a source mask. A global enable then gates the combined result at the host boundary.

Software reaches the block over a simple register bus with read and write strobes, a byte address, a byte-enable vector and 32-bit data. The mask has no plain write access. Software turns sources on through a write-one-to-set alias and turns them off through a write-one-to-clear alias. A host status register shows whether any unmasked source is active, and it does so even while the global enable is off. An interrupt handler can therefore switch the line off, look at the status, and read the pending register to find the cause. The pending register shows live levels and stores nothing. A source is cleared at its own peripheral.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the host line is low, the global enable is 0 and every mask bit is 0. The enable, mask, pending and status registers all read back as zero, whatever the request levels are.
- R2: The global enable is bit 7 of the register at byte offset 0x50. A write to that offset with byte-enable bit 0 set loads bit 7 from write data bit 7. Reads of 0x50 return the enable in bit 7, and every other bit reads as zero.
- R3: When a write makes the global enable 0, the host line is low right after the clock edge that takes the write. While the enable is 0 the host line never rises.
- R4: A write to offset 0x64 (mask set) turns on each mask bit whose write-data bit is 1. Mask bits whose data bit is 0 keep their value. A read of 0x64 returns the current mask in bits 5:0 and zero above.
- R5: A write to offset 0x68 (mask clear) turns off each mask bit whose write-data bit is 1 and leaves the other bits alone. Writing 0xFFFF turns off every source in one access.
- R6: The pending register at offset 0x60 is 16 bits wide. Bits 0 to 5 belong, in this order, to the serial-flash controller, two-wire controller 0, two-wire controller 1, DMA channel 0, DMA channel 1 and the common-interface module. Each bit equals the live request level ANDed with its mask bit. Bits 6 and up read as zero.
- R7: The host status register is at offset 0x40. Its bit 7 reads 1 exactly when at least one pending bit is 1, regardless of the global enable. Every other bit reads as zero.
- R8: The host line is a flip-flop output. At each clock edge it loads the OR of (request levels at that edge AND the mask), ANDed with the global enable. The mask and the enable used are the values that hold after any write taken at the same edge. A change in a request level therefore shows on the line after the next clock edge.
- R9: A write whose byte-enable bit 0 is 0 changes neither the global enable nor any mask bit.
- R10: Reads of any other offset return zero. The read-data bus is zero whenever the read strobe is low.
- R11: A request whose mask bit is 0 has no effect on the host line, on the pending register or on status bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte enables for the write data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_req | input | 6 | Level requests: bit 0 serial flash, 1–2 two-wire, 3–4 DMA, 5 common interface |
| host_irq | output | 1 | Registered aggregated interrupt to the host |

## Verification
The bench goes after four corner cases.

- **Timing of a disabling write.** The host line must already be low in the cycle after the write of zero. A design that gated with the old enable would hold the line high for one more cycle.
- **Status while the gate is off.** Status and pending are read while the global enable is 0. A design that tapped status after the global gate would hide the cause from the handler.
- **Zero bits in the set and clear aliases.** Partial patterns go to both aliases and the mask is read back afterwards. A design that treated the aliases as plain writes would lose the bits that were not named.
- **Lane gating.** Writes with byte-enable bit 0 low must leave every register unchanged.

Long random runs also mix request toggles with register traffic. They catch any design that lets a masked request through or that misses a level change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Register byte offsets
   localparam int unsigned OFS_HOST_STAT = 32'h40;
   localparam int unsigned OFS_GLB_EN    = 32'h50;
   localparam int unsigned OFS_PENDING   = 32'h60;
   localparam int unsigned OFS_MASK_SET  = 32'h64;
   localparam int unsigned OFS_MASK_CLR  = 32'h68;

   // Bit that carries the global gate and the host status flag
   localparam int unsigned HOST_BIT = 7;

   // Pending bit positions, in priority order of the host handler
   typedef enum int unsigned {
      SRC_FLASH = 0,
      SRC_TWI0  = 1,
      SRC_TWI1  = 2,
      SRC_DMA0  = 3,
      SRC_DMA1  = 4,
      SRC_CIF   = 5
   } src_slot_e;

   localparam int unsigned SRC_SLOTS = int'(SRC_CIF) + 1;

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_SRC = 6,
   localparam int LANES  = (NUM_SRC + 7) / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic               clr_stb,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic [LANES-1:0]   be,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] mask_d
);

   logic [NUM_SRC-1:0] wr_bits;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign wr_bits[i] = be[i/8] & wdata[i];
      assign mask_d[i]  = (mask_q[i] | (set_stb & wr_bits[i])) & ~(clr_stb & wr_bits[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   // R4: named bits become set
   p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((mask_q & $past(wr_bits)) == $past(wr_bits)));

   // R4: unnamed bits keep their value on a set access
   p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((mask_q & ~$past(wr_bits)) == ($past(mask_q) & ~$past(wr_bits))));

   // R5: named bits become clear
   p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((mask_q & $past(wr_bits)) == '0));

   // R9: no access, no change
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(mask_q));

endmodule

// File: rtl/irq_glb_enable.sv
module irq_glb_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic wbit,
   output logic en_q,
   output logic en_d
);

   assign en_d = wr_stb ? wbit : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
   end

   // R2: a qualified write loads the gate
   p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (en_q == $past(wbit)));

   // R9: otherwise the gate holds
   p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(en_q));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic [NUM_SRC-1:0] mask_d,
   input  logic               en_q,
   input  logic               en_d,
   output logic [NUM_SRC-1:0] pend,
   output logic               any_pend,
   output logic               host_irq
);

   logic line_next;

   assign pend      = src_req & mask_q;
   assign any_pend  = |pend;
   assign line_next = (|(src_req & mask_d)) & en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_irq <= 1'b0;
      else        host_irq <= line_next;
   end

   // R3: the line is never high with the gate off
   p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> en_q);

   // R3: a closing gate drops the line at the same edge
   p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_d |=> !host_irq);

   // R8/R11: a high line traces back to an unmasked request
   p_irq_needs_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> ((|($past(src_req) & mask_q)) == 1'b1));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int NUM_SRC = 6,
   parameter int PEND_W  = 16,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   output logic              host_irq
);
   import irq_agg_pkg::*;

   localparam int BE_W  = DATA_W / 8;
   localparam int LANES = (NUM_SRC + 7) / 8;

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_HOST_STAT);
   localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(OFS_GLB_EN);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MASK_SET);
   localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MASK_CLR);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > PEND_W) begin : g_bad_src
      $error("NUM_SRC must lie in 1..PEND_W");
   end
   if (PEND_W > DATA_W || DATA_W % 8 != 0 || DATA_W <= int'(HOST_BIT)) begin : g_bad_data
      $error("DATA_W must be a byte multiple holding PEND_W and the host bit");
   end
   if (LANES > BE_W) begin : g_bad_lanes
      $error("mask does not fit the byte lanes");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end
   if (NUM_SRC != int'(SRC_SLOTS)) begin : g_bad_map
      $error("NUM_SRC must match the source slot map");
   end

   logic               wr_gen, wr_mset, wr_mclr;
   logic [NUM_SRC-1:0] mask_q, mask_d, pend;
   logic               en_q, en_d, any_pend;
   logic               unused_bus;

   assign wr_gen  = bus_wr && (bus_addr == A_GEN) && bus_be[0];
   assign wr_mset = bus_wr && (bus_addr == A_MSET);
   assign wr_mclr = bus_wr && (bus_addr == A_MCLR);
   assign unused_bus = ^{bus_wdata, bus_be};

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_mset),
      .clr_stb (wr_mclr),
      .wdata   (bus_wdata[NUM_SRC-1:0]),
      .be      (bus_be[LANES-1:0]),
      .mask_q  (mask_q),
      .mask_d  (mask_d)
   );

   irq_glb_enable u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_gen),
      .wbit   (bus_wdata[HOST_BIT]),
      .en_q   (en_q),
      .en_d   (en_d)
   );

   irq_line_gen #(.NUM_SRC(NUM_SRC)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_req  (src_req),
      .mask_q   (mask_q),
      .mask_d   (mask_d),
      .en_q     (en_q),
      .en_d     (en_d),
      .pend     (pend),
      .any_pend (any_pend),
      .host_irq (host_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            A_STAT: bus_rdata[HOST_BIT]   = any_pend;
            A_GEN:  bus_rdata[HOST_BIT]   = en_q;
            A_PEND: bus_rdata[PEND_W-1:0] = PEND_W'(pend);
            A_MSET: bus_rdata[NUM_SRC-1:0] = mask_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   // R7: status flag only with a pending source; R11 masked requests stay hidden
   p_stat_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_STAT && bus_rdata[HOST_BIT]) |-> ((src_req & mask_q) != '0));

   // R10: idle bus reads zero
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  src_req = '0;
   logic        host_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // bench model
   logic [5:0] m_mask = '0;
   logic       m_en = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_aggregator u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_req(src_req), .host_irq(host_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      return (|(src_req & m_mask)) & m_en;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [31:0] r = '0;
      case (a)
         8'h40: r[7] = |(src_req & m_mask);
         8'h50: r[7] = m_en;
         8'h60: r[5:0] = src_req & m_mask;
         8'h64: r[5:0] = m_mask;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      logic [5:0] bits = be[0] ? d[5:0] : 6'h0;
      if (a == 8'h50 && be[0]) m_en = d[7];
      if (a == 8'h64) m_mask = m_mask | bits;
      if (a == 8'h68) m_mask = m_mask & ~bits;
   endtask

   task automatic op_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                           input string tag);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      model_write(a, d, be);
      chk(tag, {31'h0, host_irq}, {31'h0, exp_irq()});
   endtask

   task automatic op_tick(input logic [5:0] s, input string tag);
      @(negedge clk);
      src_req = s;
      @(posedge clk); #1;
      chk(tag, {31'h0, host_irq}, {31'h0, exp_irq()});
   endtask

   task automatic op_read(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp_rd(a));
      @(posedge clk); #1;
      bus_rd = 1'b0;
      chk("R8 line after read", {31'h0, host_irq}, {31'h0, exp_irq()});
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      src_req = 6'h3F;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 line in reset", {31'h0, host_irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: everything quiet after reset, even with all requests high
      op_read(8'h50, "R1 enable after reset");
      op_read(8'h64, "R1 mask after reset");
      op_read(8'h60, "R1 pending after reset");
      op_read(8'h40, "R1 status after reset");
      op_tick(6'h3F, "R1 line after reset");

      // R4/R7/R3: unmask all with gate off; status shows, line stays low
      op_write(8'h64, 32'h0000_003F, 4'hF, "R3 line low while gate off");
      op_read(8'h40, "R7 status with gate off");
      op_read(8'h60, "R6 pending live levels");
      op_read(8'h64, "R4 mask readback all");

      // R2/R8: gate on raises the line at the write edge
      op_write(8'h50, 32'h0000_0080, 4'h1, "R8 line rises with gate write");
      op_read(8'h50, "R2 enable readback");
      op_write(8'h50, 32'hFFFF_FF7F, 4'hF, "R3 line drops at gate-off edge");
      op_read(8'h50, "R2 enable other bits zero");

      // R9: lane 0 disabled leaves state alone
      op_write(8'h50, 32'h0000_0080, 4'hE, "R9 gate write without lane 0");
      op_read(8'h50, "R9 enable unchanged");
      op_write(8'h68, 32'h0000_003F, 4'hE, "R9 clear without lane 0");
      op_read(8'h64, "R9 mask unchanged");
      op_write(8'h50, 32'h0000_0080, 4'h1, "R8 gate back on");

      // R5: partial clear keeps unnamed bits
      op_write(8'h68, 32'h0000_0005, 4'h1, "R5 partial clear");
      op_read(8'h64, "R5 mask after partial clear");
      op_write(8'h68, 32'h0000_FFFF, 4'h3, "R5 clear all");
      op_read(8'h64, "R5 mask after clear all");

      // R11: masked requests cannot reach the line or registers
      op_tick(6'h00, "R11 idle");
      op_tick(6'h3F, "R11 masked requests ignored");
      op_read(8'h60, "R11 pending masked");
      op_read(8'h40, "R11 status masked");

      // R4/R6: single-source walk, reserved bits zero
      for (int i = 0; i < 6; i++) begin
         op_write(8'h64, 32'h1 << i, 4'h1, "R4 single set");
         op_tick(6'h00, "R8 source low drops line");
         op_tick(6'h01 << i, "R8 source high raises line");
         op_read(8'h60, "R6 single pending bit");
         op_write(8'h68, 32'h1 << i, 4'h1, "R5 single clear");
      end

      // R10: unmapped and write-only offsets
      op_read(8'h44, "R10 unmapped offset");
      op_read(8'h68, "R10 clear alias reads zero");
      @(negedge clk); bus_rd = 1'b0; bus_addr = 8'h50; #1;
      chk("R10 rdata with strobe low", bus_rdata, 32'h0);

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int op = int'($urandom % 6);
         logic [7:0] addrs [6] = '{8'h40, 8'h50, 8'h60, 8'h64, 8'h68, 8'h7C};
         case (op)
            0, 1: op_tick(6'($urandom), "R8 random tick");
            2: op_write(8'h50, $urandom, 4'($urandom), "R3 random gate write");
            3: op_write(8'h64, $urandom, 4'($urandom), "R4 random set");
            4: op_write(8'h68, $urandom, 4'($urandom), "R5 random clear");
            default: op_read(addrs[$urandom % 6], "R6 random read");
         endcase
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule